// File: doc/BRIEF.md
# Two-channel DMA control and status register file

This block holds the software-visible control and status state for two channels of a descriptor-driven DMA engine. A processor reaches it over a plain 32-bit register bus with separate write and read strobes. Each channel owns a 0x30-byte window. The window holds a control word, a status word and two descriptor pointers, and every other word slot in the window simply stores what was written to it.

The descriptor engine itself sits outside. It talks to this block through per-channel event strobes: reached the tail (idle), stopped (halted), a slave or decode fault on a bus access, a completion interrupt and a delay interrupt. In return the block drives a run level per channel, a one-cycle start pulse whenever software writes a tail pointer, and a per-channel interrupt line. That line is the status interrupt bits gated by the enables in the control word.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every control word reads 0x00010002 (value 1 in bits 23:16, bit 1 set), every status word reads 0x00000001, and run, start and irq are all low.
- R2: The channel is bit 0 of (addr / 0x30), and the word slot is (addr mod 0x30) >> 2. Slot 0 is control, slot 1 is status, slot 2 is the current-descriptor pointer and slot 4 is the tail pointer. Every slot other than control and status stores the written word and reads it back, and reads 0 after reset. The two channels keep separate state.
- R3: Control bit 1 (tail-pointer mode) always reads 1, whatever was written to it.
- R4: A control write with bit 2 set loads control with 0x00010006 and status with 0x00000001. Bit 2 then stays held until the next control read. That read returns bit 2 as 0 and clears it. While bit 2 is held, a run request does not leave the halted state.
- R5: Control bit 0 is run and drives the run output. A control write with bit 0 set, while bit 2 is not held, clears status bit 0 (halted) and status bit 1 (idle).
- R6: Writing 1 to any of status bits 14:12 clears that bit, and writing 0 leaves it unchanged. A status write changes no other status bit. Status bits 31:16 read 0.
- R7: A write to the tail slot stores the word and clears the idle bit. It also raises that channel's start output for exactly one cycle, in the cycle after the write.
- R8: irq of a channel is high exactly when status bits 14:12 AND control bits 14:12 is non-zero. Bit 12 is completion, bit 13 is delay and bit 14 is error.
- R9: The event strobes set status bits: idle sets bit 1, halted sets bit 0, completion sets bit 12 and delay sets bit 13. An event wins over a bus write to the same channel in the same cycle.
- R10: A slave-error strobe sets status bit 5 and a decode-error strobe sets status bit 6. Either one also sets halted (bit 0) and the error interrupt (bit 14), and clears control bit 0.
- R11: Read data is registered: rd_valid is high, and rdata holds the addressed word, in the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset into the two-channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| ev_idle | input | 2 | Per-channel idle event |
| ev_halt | input | 2 | Per-channel halted event |
| ev_slverr | input | 2 | Per-channel slave error event |
| ev_decerr | input | 2 | Per-channel decode error event |
| ev_ioc | input | 2 | Per-channel completion interrupt event |
| ev_dly | input | 2 | Per-channel delay interrupt event |
| run | output | 2 | Per-channel run bit |
| start | output | 2 | Per-channel one-cycle start pulse after a tail write |
| irq | output | 2 | Per-channel masked interrupt |

## Verification
Status writes are tried with all-zero data, with every bit set except one pending interrupt bit, and with exactly the pending bit set. Only the last may clear it, so these patterns separate write-one-to-clear behaviour from plain overwrite and from write-zero-to-clear. Interrupts are raised with their enable on and with it off, which separates masked from unmasked output. A reset write followed by a run write with no read in between shows whether the held reset bit blocks the start. Addresses in the second window, and in aliased copies of both windows, show that the channel decode and per-channel storage are kept apart. An error strobe that coincides with a status write shows the event taking priority over the write.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [1:0]        ev_idle,
  input  logic [1:0]        ev_halt,
  input  logic [1:0]        ev_slverr,
  input  logic [1:0]        ev_decerr,
  input  logic [1:0]        ev_ioc,
  input  logic [1:0]        ev_dly,
  output logic [1:0]        run,
  output logic [1:0]        start,
  output logic [1:0]        irq
);
  localparam int WIN   = 48;
  localparam int WORDS = WIN / 4;
  localparam logic [31:0] CTRL_INIT  = 32'h0001_0002;
  localparam logic [31:0] CTRL_SOFT  = 32'h0001_0006;
  localparam logic [31:0] STAT_INIT  = 32'h0000_0001;

  logic [ADDR_W-1:0] blk, off;
  logic              chsel;
  logic [3:0]        slot;

  assign blk   = addr / ADDR_W'(WIN);
  assign off   = addr % ADDR_W'(WIN);
  assign chsel = blk[0];
  assign slot  = off[5:2];

  logic [31:0] ctrl_q [2];
  logic [31:0] stat_q [2];
  logic [31:0] nctrl  [2];
  logic [31:0] nstat  [2];
  logic [31:0] words_q [2][WORDS];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      nctrl[c] = ctrl_q[c];
      nstat[c] = stat_q[c];
      if (rd_en && int'(chsel) == c && slot == 4'd0)
        nctrl[c][2] = 1'b0;
      if (wr_en && int'(chsel) == c) begin
        case (slot)
          4'd0: begin
            if (wdata[2]) begin
              nctrl[c] = CTRL_SOFT;
              nstat[c] = STAT_INIT;
            end else begin
              nctrl[c] = wdata | 32'h2 | (nctrl[c] & 32'h4);
              if (wdata[0] && !nctrl[c][2])
                nstat[c][1:0] = 2'b00;
            end
          end
          4'd1: nstat[c][14:12] = stat_q[c][14:12] & ~wdata[14:12];
          4'd4: nstat[c][1] = 1'b0;
          default: ;
        endcase
      end
      if (ev_idle[c]) nstat[c][1]  = 1'b1;
      if (ev_halt[c]) nstat[c][0]  = 1'b1;
      if (ev_ioc[c])  nstat[c][12] = 1'b1;
      if (ev_dly[c])  nstat[c][13] = 1'b1;
      if (ev_slverr[c]) nstat[c][5] = 1'b1;
      if (ev_decerr[c]) nstat[c][6] = 1'b1;
      if (ev_slverr[c] || ev_decerr[c]) begin
        nstat[c][0]  = 1'b1;
        nstat[c][14] = 1'b1;
        nctrl[c][0]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        ctrl_q[c] <= CTRL_INIT;
        stat_q[c] <= STAT_INIT;
        for (int w = 0; w < WORDS; w++) words_q[c][w] <= '0;
      end
      start    <= '0;
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        ctrl_q[c] <= nctrl[c];
        stat_q[c] <= nstat[c];
        start[c]  <= wr_en && slot == 4'd4 && int'(chsel) == c;
      end
      if (wr_en && slot > 4'd1)
        words_q[chsel][slot] <= wdata;
      rd_valid <= rd_en;
      if (rd_en) begin
        case (slot)
          4'd0:    rdata <= ctrl_q[chsel] & ~32'h4;
          4'd1:    rdata <= stat_q[chsel];
          default: rdata <= words_q[chsel][slot];
        endcase
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_out
    assign run[c] = ctrl_q[c][0];
    assign irq[c] = |(stat_q[c][14:12] & ctrl_q[c][14:12]);
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              rd_valid,
  input logic [1:0]        ev_slverr,
  input logic [1:0]        ev_decerr,
  input logic [1:0]        run,
  input logic [1:0]        start
);
  logic tail_hit, ctrl_rd, ctrl_rd_q;
  assign tail_hit = wr_en && (addr % ADDR_W'(48)) == ADDR_W'(16);
  assign ctrl_rd  = rd_en && (addr % ADDR_W'(48)) == ADDR_W'(0);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_rd_q <= 1'b0;
    else        ctrl_rd_q <= ctrl_rd;
  end

  assert_start_after_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tail_hit |=> $countones(start) == 1);
  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));
  assert_no_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_hit |=> start == 2'b00);
  assert_err_stops_ch0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slverr[0] || ev_decerr[0]) |=> !run[0]);
  assert_err_stops_ch1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slverr[1] || ev_decerr[1]) |=> !run[1]);
  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_tailmode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && ctrl_rd_q) |-> (rdata[1] && !rdata[2]));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_valid(rd_valid), .ev_slverr(ev_slverr),
  .ev_decerr(ev_decerr), .run(run), .start(start)
);

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid;
  logic [1:0] ev_idle = '0, ev_halt = '0, ev_slverr = '0, ev_decerr = '0, ev_ioc = '0, ev_dly = '0;
  logic [1:0] run, start, irq;

  always #2 clk = ~clk;

  dma_chan_regs #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .ev_idle(ev_idle),
    .ev_halt(ev_halt), .ev_slverr(ev_slverr), .ev_decerr(ev_decerr),
    .ev_ioc(ev_ioc), .ev_dly(ev_dly), .run(run), .start(start), .irq(irq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R11 unexpected read data", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ev(input int k, input int c);
    @(negedge clk);
    case (k)
      0: ev_idle[c] = 1'b1;
      1: ev_halt[c] = 1'b1;
      2: ev_slverr[c] = 1'b1;
      3: ev_decerr[c] = 1'b1;
      4: ev_ioc[c] = 1'b1;
      default: ev_dly[c] = 1'b1;
    endcase
    @(negedge clk);
    ev_idle = '0; ev_halt = '0; ev_slverr = '0; ev_decerr = '0; ev_ioc = '0; ev_dly = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 run", 32'(run), 0); chk("R1 irq", 32'(irq), 0); chk("R1 start", 32'(start), 0);
    rd(8'h00, 32'h0001_0002, "R1 ctrl0");
    rd(8'h04, 32'h0000_0001, "R1 stat0");
    rd(8'h30, 32'h0001_0002, "R1 ctrl1");
    rd(8'h34, 32'h0000_0001, "R1 stat1");
    rd(8'h0C, 32'h0, "R2 spare slot after reset");

    wr(8'h00, 32'h0000_7001);
    chk("R5 run out", 32'(run), 32'h1);
    rd(8'h00, 32'h0000_7003, "R3 tail mode forced");
    rd(8'h04, 32'h0, "R5 halted and idle cleared");

    ev(4, 0);
    chk("R8 irq on ioc", 32'(irq), 32'h1);
    rd(8'h04, 32'h0000_1000, "R9 ioc bit");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0000_1000, "R6 write zero keeps");
    wr(8'h04, 32'hFFFF_EFFF);
    rd(8'h04, 32'h0000_1000, "R6 other bits unaffected");
    wr(8'h04, 32'h0000_1000);
    chk("R8 irq after clear", 32'(irq), 32'h0);
    rd(8'h04, 32'h0, "R6 w1c");

    wr(8'h00, 32'h0000_4001);
    rd(8'h00, 32'h0000_4003, "R3 ctrl readback");
    ev(5, 0);
    chk("R8 masked delay irq", 32'(irq), 32'h0);
    rd(8'h04, 32'h0000_2000, "R9 delay bit");
    wr(8'h04, 32'h0000_2000);
    rd(8'h04, 32'h0, "R6 clear delay");

    wr(8'h10, 32'h0000_1234);
    chk("R7 start pulse", 32'(start), 32'h1);
    @(negedge clk);
    chk("R7 start one cycle", 32'(start), 32'h0);
    rd(8'h10, 32'h0000_1234, "R7 tail stored");
    ev(0, 0);
    rd(8'h04, 32'h0000_0002, "R9 idle bit");
    wr(8'h10, 32'h0000_1240);
    rd(8'h04, 32'h0, "R7 tail clears idle");
    ev(1, 0);
    rd(8'h04, 32'h0000_0001, "R9 halt bit");

    ev(3, 0);
    chk("R10 run cleared", 32'(run), 32'h0);
    chk("R10 err irq", 32'(irq), 32'h1);
    rd(8'h04, 32'h0000_4041, "R10 decode error status");
    rd(8'h00, 32'h0000_4002, "R10 ctrl run cleared");

    wr(8'h00, 32'h0000_0005);
    chk("R4 irq after soft reset", 32'(irq), 32'h0);
    rd(8'h00, 32'h0001_0002, "R4 ctrl after soft reset");
    rd(8'h04, 32'h0000_0001, "R4 stat after soft reset");
    wr(8'h00, 32'h0000_0004);
    wr(8'h00, 32'h0000_0001);
    rd(8'h04, 32'h0000_0001, "R4 held reset blocks run");
    rd(8'h00, 32'h0000_0003, "R4 reset bit hidden");
    wr(8'h00, 32'h0000_0001);
    rd(8'h04, 32'h0, "R5 run after reset released");

    wr(8'h30, 32'h0000_0001);
    chk("R2 ch1 run", 32'(run), 32'h3);
    rd(8'h90, 32'h0000_0003, "R2 alias ch1");
    rd(8'h60, 32'h0000_0003, "R2 alias ch0");
    wr(8'h3C, 32'hDEAD_BEEF);
    rd(8'h3C, 32'hDEAD_BEEF, "R2 spare slot ch1");
    rd(8'h0C, 32'h0, "R2 spare slot ch0 separate");
    wr(8'h08, 32'h0000_1000);
    rd(8'h08, 32'h0000_1000, "R2 current pointer");

    ev(2, 1);
    chk("R10 ch1 run cleared", 32'(run), 32'h1);
    chk("R8 ch1 irq masked", 32'(irq), 32'h0);
    rd(8'h34, 32'h0000_4021, "R10 slave error status");
    rd(8'h04, 32'h0, "R2 ch0 untouched");

    @(negedge clk); wr_en = 1'b1; addr = 8'h34; wdata = 32'h0000_4000; ev_slverr[1] = 1'b1;
    @(negedge clk); wr_en = 1'b0; ev_slverr = '0;
    rd(8'h34, 32'h0000_4021, "R9 event wins over write");

    repeat (3) @(negedge clk);
    chk("R11 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule